// File: doc/BRIEF.md
# Pipelined Signed Multiplier with Registered Partial-Product Cascade

This block multiplies two 35-bit two's-complement operands and returns the exact 70-bit signed product. Each operand is cut into a 17-bit low slice and an 18-bit signed high slice. Four multiplies, each no wider than 18x18 signed, produce the partial products. A chain of adders then accumulates them, with a register after every adder, so no adder feeds the next one through combinational logic.

Every partial product is registered on its own before it joins the running sum. The operand copies that feed later multiplies pass through more delay registers than the copies that feed earlier ones. As a result each adder combines terms that all come from the same input sample. A parameter appends extra register stages after the final sum.

A new operand pair may enter on every clock. Results leave in input order, one per cycle. A valid flag travels with each pair and marks the matching product. The datapath registers have no reset. Only the valid pipeline is cleared.

Top module: `sliced_mul_pipe`

## Requirements
- R1: `product` equals the full signed product of `op_a` and `op_b` (both 35-bit two's complement), sign-extended to 70 bits, with no rounding or truncation.
- R2: The product of a pair sampled at rising edge N appears on `product` after rising edge N+4+EXTRA_STAGES, which is a latency of 5+EXTRA_STAGES edges counting the sampling edge.
- R3: A new operand pair is accepted on every clock edge, and products leave in input order with one result per cycle.
- R4: `out_valid` equals `in_valid` delayed by the same latency as the product. While `rst_n` is low (synchronous, active low), `out_valid` is 0, and it stays 0 until a valid pair sampled after reset reaches the output.
- R5: The most negative operand times itself (-2^34 * -2^34) yields +2^68.
- R6: The most negative operand times the most positive (-2^34 * (2^34-1)) yields -2^68+2^34.
- R7: A zero operand yields a zero product, and operands of +1 or -1 (all ones) yield the other operand or its negation.
- R8: The datapath does not stall on `in_valid` low. A pair sampled with `in_valid` low still produces its product at the normal latency, with `out_valid` low.
- R9: The accumulation order is low×low plus the first cross product first, the second cross product next, and high×high (weight 2^34) last. After the second adder, the running sum equals the full product minus the high×high term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks the operand pair as valid |
| op_a | input | 35 | Signed multiplicand |
| op_b | input | 35 | Signed multiplier |
| out_valid | output | 1 | Marks `product` as the result of a valid pair |
| product | output | 70 | Signed product |

## Verification
The hardest condition to reach from the ports is a set of carries and sign extensions that spread across all four partial products at once. Extreme operands are the ones that do this: the most negative value, the most positive value, and all-ones. The stimulus streams these back-to-back with mixed-sign table vectors so that every pipeline stage holds a different sample. Valid pulses are interleaved with bubbles so that any skew between the valid pipeline and the data shows up as a mismatch at the output.

// File: rtl/sliced_mul_pipe.sv
module sliced_mul_pipe #(
  parameter int OPW = 35,
  parameter int LOW = 17,
  parameter int EXTRA_STAGES = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [OPW-1:0]        op_a,
  input  logic [OPW-1:0]        op_b,
  output logic                  out_valid,
  output logic signed [2*OPW-1:0] product
);
  localparam int SW  = OPW - LOW;
  localparam int MW  = 2 * SW;
  localparam int PW  = 2 * OPW;
  localparam int LAT = 5 + EXTRA_STAGES;

  function automatic logic signed [SW-1:0] lo_of(input logic [OPW-1:0] x);
    return signed'(SW'(x[LOW-1:0]));
  endfunction

  function automatic logic signed [SW-1:0] hi_of(input logic [OPW-1:0] x);
    return signed'(x[OPW-1:LOW]);
  endfunction

  function automatic logic signed [MW-1:0] smul(input logic signed [SW-1:0] x,
                                               input logic signed [SW-1:0] y);
    logic signed [MW-1:0] xe, ye;
    xe = MW'(x);
    ye = MW'(y);
    return xe * ye;
  endfunction

  logic [OPW-1:0] a_d [3];
  logic [OPW-1:0] b_d [3];
  logic signed [MW-1:0] m_ll, m_lh, m_hl, m_hh;
  logic signed [PW-1:0] s1, s2, s3;
  logic [LAT-1:0] vq;

  always_ff @(posedge clk) begin
    a_d[0] <= op_a;
    b_d[0] <= op_b;
    for (int k = 1; k < 3; k++) begin
      a_d[k] <= a_d[k-1];
      b_d[k] <= b_d[k-1];
    end
  end

  always_ff @(posedge clk) begin
    m_ll <= smul(lo_of(a_d[0]), lo_of(b_d[0]));
    m_lh <= smul(lo_of(a_d[0]), hi_of(b_d[0]));
    m_hl <= smul(hi_of(a_d[1]), lo_of(b_d[1]));
    m_hh <= smul(hi_of(a_d[2]), hi_of(b_d[2]));
  end

  always_ff @(posedge clk) begin
    s1 <= PW'(m_ll) + (PW'(m_lh) <<< LOW);
    s2 <= s1 + (PW'(m_hl) <<< LOW);
    s3 <= s2 + (PW'(m_hh) <<< (2 * LOW));
  end

  generate
    if (EXTRA_STAGES == 0) begin : g_direct
      assign product = s3;
    end else begin : g_outpipe
      logic signed [PW-1:0] opipe [EXTRA_STAGES];
      always_ff @(posedge clk) begin
        opipe[0] <= s3;
        for (int k = 1; k < EXTRA_STAGES; k++) opipe[k] <= opipe[k-1];
      end
      assign product = opipe[EXTRA_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) vq <= '0;
    else        vq <= {vq[LAT-2:0], in_valid};
  end

  assign out_valid = vq[LAT-1];

  function automatic logic signed [PW-1:0] full_ref(input logic [OPW-1:0] x,
                                                    input logic [OPW-1:0] y);
    logic signed [PW-1:0] xe, ye;
    xe = PW'(signed'(x));
    ye = PW'(signed'(y));
    return xe * ye;
  endfunction

  function automatic logic signed [PW-1:0] top_ref(input logic [OPW-1:0] x,
                                                   input logic [OPW-1:0] y);
    logic signed [PW-1:0] xe, ye;
    xe = PW'(signed'(x[OPW-1:LOW]));
    ye = PW'(signed'(y[OPW-1:LOW]));
    return (xe * ye) <<< (2 * LOW);
  endfunction

  function automatic logic signed [PW-1:0] cross2_ref(input logic [OPW-1:0] x,
                                                      input logic [OPW-1:0] y);
    logic signed [PW-1:0] xe, ye;
    xe = PW'(signed'(x[OPW-1:LOW]));
    ye = signed'(PW'(y[LOW-1:0]));
    return (xe * ye) <<< LOW;
  endfunction

  a_r1_full_product: assert property (@(posedge clk) disable iff (!rst_n)
    vq[4] |-> s3 == $past(full_ref(a_d[2], b_d[2]), 2));

  a_r9_sum_after_cross: assert property (@(posedge clk) disable iff (!rst_n)
    vq[3] |-> s2 == $past(full_ref(a_d[1], b_d[1]) - top_ref(a_d[1], b_d[1]), 2));

  a_r9_sum_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    vq[2] |-> s1 == $past(full_ref(a_d[0], b_d[0]) - top_ref(a_d[0], b_d[0])
                          - cross2_ref(a_d[0], b_d[0]), 2));

  a_r4_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (vq[4] && $past(a_d[2] == '0, 2)) |-> s3 == '0);
endmodule

// File: tb/sliced_mul_pipe_test.sv
module sliced_mul_pipe_test;
  localparam int EXTRA = 1;
  localparam int LAT = 5 + EXTRA;
  localparam int NV = 12;
  localparam logic [34:0] TA [NV] = '{
    35'h0_0000_0003, 35'h7_FFFF_FFF9, 35'h1_2345_6789, 35'h5_4321_0FED,
    35'h0_0001_FFFF, 35'h0_0002_0000, 35'h3_0F0F_0F0F, 35'h4_AAAA_5555,
    35'h2_DEAD_BEEF, 35'h7_0000_0001, 35'h0_0000_FFFF, 35'h6_CAFE_F00D};
  localparam logic [34:0] TB [NV] = '{
    35'h0_0000_0005, 35'h0_0000_000B, 35'h7_6543_2101, 35'h2_1111_2222,
    35'h0_0001_FFFF, 35'h7_FFFE_0000, 35'h4_F0F0_F0F0, 35'h5_5555_AAAA,
    35'h3_1234_ABCD, 35'h0_FFFF_FFFF, 35'h1_8000_0001, 35'h6_BEEF_1234};
  localparam logic [34:0] MINV = 35'h4_0000_0000;
  localparam logic [34:0] MAXV = 35'h3_FFFF_FFFF;
  localparam logic [34:0] NEG1 = 35'h7_FFFF_FFFF;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [34:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic signed [69:0] product;

  sliced_mul_pipe #(.EXTRA_STAGES(EXTRA)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product));

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0, failures = 0;
  bit done = 0;
  bit rec [1024];
  logic signed [69:0] exp_p [1024];
  bit exp_v [1024];
  string req_s [1024];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic signed [69:0] ref_mul(input logic [34:0] a, input logic [34:0] b);
    logic signed [69:0] x, y;
    x = {{35{a[34]}}, a};
    y = {{35{b[34]}}, b};
    return x * y;
  endfunction

  task automatic drive(input logic [34:0] a, input logic [34:0] b, input bit v, input string req);
    @(posedge clk);
    #2;
    op_a = a; op_b = b; in_valid = v;
    if (cyc < 1024) begin
      rec[cyc] = 1; exp_p[cyc] = ref_mul(a, b); exp_v[cyc] = v; req_s[cyc] = req;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc >= LAT && cyc - LAT < 1024 && rec[cyc-LAT]) begin
      int i;
      i = cyc - LAT;
      checks++;
      if (out_valid !== exp_v[i] || product !== exp_p[i]) begin
        failures++;
        $display("FAIL %s: valid=%0b product=%0d expected valid=%0b product=%0d",
                 req_s[i], out_valid, product, exp_v[i], exp_p[i]);
      end
    end
  end

  initial begin
    rst_n = 0;
    in_valid = 1;
    op_a = MAXV; op_b = MAXV;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R4: out_valid=%0b during reset, expected 0", out_valid);
    end
    @(posedge clk); #2;
    rst_n = 1;
    in_valid = 0;
    for (int k = 0; k < 3; k++) drive(35'h1_0000_0007 + 35'(k), 35'h0_0000_0003, 0, "R4");
    drive(35'h0_0000_0007, 35'h7_FFFF_FFFD, 1, "R2");
    for (int k = 0; k < LAT + 1; k++) drive(35'(k * 1234567), NEG1, 0, "R8");
    for (int k = 0; k < NV; k++) drive(TA[k], TB[k], 1, "R1");
    drive(MINV, MINV, 1, "R5");
    drive(MINV, MAXV, 1, "R6");
    drive(MAXV, MINV, 1, "R6");
    drive('0, MINV, 1, "R7");
    drive(MAXV, '0, 1, "R7");
    drive(35'h0_0000_0001, TA[2], 1, "R7");
    drive(NEG1, TA[3], 1, "R7");
    drive(NEG1, NEG1, 1, "R7");
    drive(NEG1, MINV, 1, "R7");
    for (int k = 0; k < NV; k++) drive(TB[k], TA[k], (k % 3) != 1, "R3");
    for (int k = 0; k < 4; k++) drive(TA[k] ^ TB[NV-1-k], TB[k], 1, "R9");
    for (int k = 0; k < LAT + 2; k++) drive('0, '0, 0, "R8");
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule